// File: doc/BRIEF.md
# Memory-mapped compact UART

This block is a small serial port for a processor bus. Software reaches it through four word-spaced registers in a 16-byte window on a simple single-cycle bus with 32-bit data. Reads return data in the same cycle as the request, and their side effects (popping a character, clearing error flags) take effect at the clock edge that ends the access. Writes take effect at that same edge. A 16-entry transmit FIFO feeds a bit-level serializer. A bit-level deserializer fills a 16-entry receive FIFO.

The line format is fixed at build time through parameters: the bit rate (set as a clock divider for a 16x oversampling tick), the character width from 5 to 8 bits, parity on or off, and odd or even parity. Every frame has one start bit, the data bits least significant first, the optional parity bit, and one stop bit. A single status byte reports FIFO state, the interrupt enable and three sticky receive errors. The control register holds only the two FIFO flushes and the interrupt enable. The interrupt output is a short high pulse, so a processor that triggers on rising edges sees one fresh edge for each event.

Top module: `ul_lite_uart`

## Requirements
- R1: After reset the status byte reads 0x04, reads at offset 0x0 return 0, `txd_o` is high and `irq_o` is low.
- R2: A received frame (start bit low, DATA_BITS data bits least significant first, the optional parity bit, a high stop bit) is sampled on a 16x tick. The start bit is checked again at mid-bit. The character then appears at offset 0x0, zero-extended to 32 bits, and status bit 0 (receive data valid) is set.
- R3: A read at offset 0x0 while the receive FIFO is empty returns 0 and leaves the FIFO state unchanged.
- R4: Characters written at offset 0x4 go out on `txd_o` in write order. Each uses the same frame format, and the parity bit makes the total count of ones odd (odd mode) or even (even mode).
- R5: A write at offset 0x4 while status bit 3 (transmit FIFO full) is set is dropped.
- R6: The receive FIFO holds 16 characters and status bit 1 shows it full. A character that arrives while it is full is discarded and sets status bit 5 (overrun).
- R7: Status bit 6 (framing) is set when the sampled stop bit is low. Status bit 7 (parity) is set on a parity mismatch. Bits 5 to 7 are sticky and clear at the end of a status read at offset 0x8.
- R8: A write at offset 0xC with bit 0 set empties the transmit FIFO, so the next status read shows bit 2 (transmit empty) set. With bit 1 set it empties the receive FIFO, clearing status bit 0.
- R9: A write at offset 0xC sets the interrupt enable from data bit 4. Any such write with bit 4 clear disables interrupts. The enable reads back at status bit 4.
- R10: While enabled, `irq_o` pulses high for one cycle when the receive FIFO goes from empty to holding data, and when the transmit FIFO goes from holding data to empty. While disabled it stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Byte address in the 16-byte window; bits 3:2 pick the register |
| we_i | input | 1 | Write request for this cycle |
| re_i | input | 1 | Read request for this cycle |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the cycle of the request |
| rxd_i | input | 1 | Serial receive line, idle high |
| txd_o | output | 1 | Serial transmit line, idle high |
| irq_o | output | 1 | Interrupt pulse |

## Verification
The hardest conditions to reach from the ports are a receive overrun and a dropped transmit write. Both need a FIFO held full while the serial engines keep running. The bench sends seventeen receive frames back to back with no reads in between, then checks the full and overrun flags and that only the first sixteen characters come back. On the transmit side it writes eighteen characters in a burst much shorter than one frame time. The engine takes the first character at once and the FIFO fills behind it, so exactly one write is dropped. A serial decoder in the bench counts the characters that actually leave the line.

// File: rtl/ul_pkg.sv
package ul_pkg;
  localparam logic [1:0] SEL_RXD  = 2'd0;
  localparam logic [1:0] SEL_TXD  = 2'd1;
  localparam logic [1:0] SEL_STAT = 2'd2;
  localparam logic [1:0] SEL_CTRL = 2'd3;

  localparam int CTL_TX_FLUSH = 0;
  localparam int CTL_RX_FLUSH = 1;
  localparam int CTL_IE       = 4;

  localparam int OVS = 16;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_state_e;
endpackage

// File: rtl/ul_fifo.sv
module ul_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          pop_i,
  output logic [W-1:0]  rdata_o,
  output logic          empty_o,
  output logic          full_o,
  output logic [$clog2(DEPTH+1)-1:0] count_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem_q[rp_q];
  assign count_o = cnt_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= nxt(wp_q);
      if (do_pop)  rp_q <= nxt(rp_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + CW'(1);
      else if (do_pop && !do_push) cnt_q <= cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push && !flush_i) mem_q[wp_q] <= wdata_i;
  end

  AST_FIFO_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH)); // R6
endmodule

// File: rtl/ul_tx.sv
module ul_tx #(
  parameter int DATA_BITS  = 8,
  parameter int PARITY_EN  = 0,
  parameter int PARITY_ODD = 0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic                 avail_i,
  input  logic [DATA_BITS-1:0] data_i,
  output logic                 pop_o,
  output logic                 txd_o
);
  localparam int FRAME = DATA_BITS + PARITY_EN + 2;
  localparam int CW    = $clog2(FRAME+1);

  logic             busy_q;
  logic [FRAME-1:0] shf_q, frame_w;
  logic [3:0]       sub_q;
  logic [CW-1:0]    left_q;

  if (PARITY_EN != 0) begin : g_par
    assign frame_w = {1'b1, (^data_i) ^ (PARITY_ODD != 0), data_i, 1'b0};
  end else begin : g_npar
    assign frame_w = {1'b1, data_i, 1'b0};
  end

  assign pop_o = !busy_q && avail_i;
  assign txd_o = busy_q ? shf_q[0] : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      shf_q  <= '1;
      sub_q  <= '0;
      left_q <= '0;
    end else if (pop_o) begin
      busy_q <= 1'b1;
      shf_q  <= frame_w;
      sub_q  <= '0;
      left_q <= CW'(FRAME);
    end else if (busy_q && tick_i) begin
      if (sub_q == 4'(ul_pkg::OVS-1)) begin
        sub_q  <= '0;
        shf_q  <= {1'b1, shf_q[FRAME-1:1]};
        left_q <= left_q - CW'(1);
        if (left_q == CW'(1)) busy_q <= 1'b0;
      end else begin
        sub_q <= sub_q + 4'd1;
      end
    end
  end

  AST_TX_STOP_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> $past(txd_o)); // R4
endmodule

// File: rtl/ul_rx.sv
module ul_rx #(
  parameter int DATA_BITS  = 8,
  parameter int PARITY_EN  = 0,
  parameter int PARITY_ODD = 0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic                 rxd_i,
  output logic                 valid_o,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 frame_err_o,
  output logic                 par_err_o
);
  import ul_pkg::*;
  localparam int NB = DATA_BITS + PARITY_EN + 1;
  localparam int IW = $clog2(NB);

  rx_state_e     st_q;
  logic          rxd_q;
  logic [3:0]    sub_q;
  logic [IW-1:0] idx_q;
  logic [NB-1:0] sh_q, full_w;
  logic          perr_w;

  assign full_w = {rxd_i, sh_q[NB-1:1]};

  if (PARITY_EN != 0) begin : g_par
    assign perr_w = ((^full_w[DATA_BITS-1:0]) ^ full_w[DATA_BITS]) != (PARITY_ODD != 0);
  end else begin : g_npar
    assign perr_w = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= RX_IDLE;
      rxd_q       <= 1'b1;
      sub_q       <= '0;
      idx_q       <= '0;
      sh_q        <= '0;
      valid_o     <= 1'b0;
      data_o      <= '0;
      frame_err_o <= 1'b0;
      par_err_o   <= 1'b0;
    end else begin
      rxd_q   <= rxd_i;
      valid_o <= 1'b0;
      unique case (st_q)
        RX_IDLE: if (rxd_q && !rxd_i) begin
          st_q  <= RX_START;
          sub_q <= '0;
        end
        RX_START: if (tick_i) begin
          if (sub_q == 4'(OVS/2-1)) begin
            sub_q <= '0;
            idx_q <= '0;
            st_q  <= rxd_i ? RX_IDLE : RX_BITS;
          end else begin
            sub_q <= sub_q + 4'd1;
          end
        end
        RX_BITS: if (tick_i) begin
          if (sub_q == 4'(OVS-1)) begin
            sub_q <= '0;
            sh_q  <= full_w;
            if (idx_q == IW'(NB-1)) begin
              st_q        <= RX_IDLE;
              valid_o     <= 1'b1;
              data_o      <= full_w[DATA_BITS-1:0];
              frame_err_o <= !full_w[NB-1];
              par_err_o   <= perr_w;
            end else begin
              idx_q <= idx_q + IW'(1);
            end
          end else begin
            sub_q <= sub_q + 4'd1;
          end
        end
        default: st_q <= RX_IDLE;
      endcase
    end
  end

  AST_RX_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R2
endmodule

// File: rtl/ul_lite_uart.sv
module ul_lite_uart #(
  parameter int TICK_DIV   = 54,
  parameter int DATA_BITS  = 8,
  parameter int PARITY_EN  = 0,
  parameter int PARITY_ODD = 0,
  parameter int FIFO_DEPTH = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [3:0]  addr_i,
  input  logic        we_i,
  input  logic        re_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic        rxd_i,
  output logic        txd_o,
  output logic        irq_o
);
  import ul_pkg::*;
  localparam int TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int CW = $clog2(FIFO_DEPTH+1);

  logic [TW-1:0] tdiv_q;
  logic          tick;
  logic          rxd_s1_q, rxd_s2_q;
  logic [1:0]    sel;
  logic          rd_rx, wr_tx, rd_st, wr_ct;
  logic          tx_pop, tx_empty, tx_full;
  logic [DATA_BITS-1:0] tx_head, rx_head, rx_char;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic          rx_empty, rx_full, rx_valid, rx_ferr, rx_perr;
  logic          ie_q, ovr_q, frm_q, par_q;
  logic          rx_empty_d_q, tx_empty_d_q, ev;
  logic [7:0]    status;

  // oversampling tick
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tdiv_q <= '0;
    else if (tick) tdiv_q <= '0;
    else tdiv_q <= tdiv_q + TW'(1);
  end
  assign tick = (tdiv_q == TW'(TICK_DIV-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rxd_s1_q <= 1'b1;
      rxd_s2_q <= 1'b1;
    end else begin
      rxd_s1_q <= rxd_i;
      rxd_s2_q <= rxd_s1_q;
    end
  end

  assign sel   = addr_i[3:2];
  assign rd_rx = re_i && (sel == SEL_RXD);
  assign wr_tx = we_i && (sel == SEL_TXD);
  assign rd_st = re_i && (sel == SEL_STAT);
  assign wr_ct = we_i && (sel == SEL_CTRL);

  ul_fifo #(.W(DATA_BITS), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk_i, .rst_ni,
    .flush_i (wr_ct && wdata_i[CTL_TX_FLUSH]),
    .push_i  (wr_tx),
    .wdata_i (wdata_i[DATA_BITS-1:0]),
    .pop_i   (tx_pop),
    .rdata_o (tx_head),
    .empty_o (tx_empty),
    .full_o  (tx_full),
    .count_o (tx_cnt)
  );

  ul_tx #(.DATA_BITS(DATA_BITS), .PARITY_EN(PARITY_EN), .PARITY_ODD(PARITY_ODD)) u_tx (
    .clk_i, .rst_ni,
    .tick_i  (tick),
    .avail_i (!tx_empty),
    .data_i  (tx_head),
    .pop_o   (tx_pop),
    .txd_o
  );

  ul_rx #(.DATA_BITS(DATA_BITS), .PARITY_EN(PARITY_EN), .PARITY_ODD(PARITY_ODD)) u_rx (
    .clk_i, .rst_ni,
    .tick_i      (tick),
    .rxd_i       (rxd_s2_q),
    .valid_o     (rx_valid),
    .data_o      (rx_char),
    .frame_err_o (rx_ferr),
    .par_err_o   (rx_perr)
  );

  ul_fifo #(.W(DATA_BITS), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk_i, .rst_ni,
    .flush_i (wr_ct && wdata_i[CTL_RX_FLUSH]),
    .push_i  (rx_valid),
    .wdata_i (rx_char),
    .pop_i   (rd_rx),
    .rdata_o (rx_head),
    .empty_o (rx_empty),
    .full_o  (rx_full),
    .count_o (rx_cnt)
  );

  // control and sticky errors; a new error wins over a clearing read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_q  <= 1'b0;
      ovr_q <= 1'b0;
      frm_q <= 1'b0;
      par_q <= 1'b0;
    end else begin
      if (wr_ct) ie_q <= wdata_i[CTL_IE];
      ovr_q <= (rx_valid && rx_full)  || (ovr_q && !rd_st);
      frm_q <= (rx_valid && rx_ferr)  || (frm_q && !rd_st);
      par_q <= (rx_valid && rx_perr)  || (par_q && !rd_st);
    end
  end

  assign status = {par_q, frm_q, ovr_q, ie_q, tx_full, tx_empty, rx_full, !rx_empty};

  always_comb begin
    unique case (sel)
      SEL_RXD:  rdata_o = rx_empty ? 32'd0 : {{(32-DATA_BITS){1'b0}}, rx_head};
      SEL_STAT: rdata_o = {24'd0, status};
      default:  rdata_o = 32'd0;
    endcase
  end

  // interrupt: one-cycle pulse per FIFO transition
  assign ev = (rx_empty_d_q && !rx_empty) || (!tx_empty_d_q && tx_empty);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_empty_d_q <= 1'b1;
      tx_empty_d_q <= 1'b1;
      irq_o        <= 1'b0;
    end else begin
      rx_empty_d_q <= rx_empty;
      tx_empty_d_q <= tx_empty;
      irq_o        <= ie_q && ev;
    end
  end

  logic unused_bits;
  assign unused_bits = ^{addr_i[1:0], wdata_i[31:8], rx_cnt};

  AST_TX_FLUSH_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ct && wdata_i[CTL_TX_FLUSH]) |=> tx_empty); // R8
  AST_RX_FLUSH_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ct && wdata_i[CTL_RX_FLUSH]) |=> rx_empty); // R8
  AST_TX_FULL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_tx && tx_full && !tx_pop) |=> (tx_cnt == $past(tx_cnt))); // R5
  AST_OVR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid && rx_full) |=> ovr_q); // R6
  AST_EMPTY_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_rx && rx_empty) |-> (rdata_o == 32'd0)); // R3
  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(ie_q)); // R10
endmodule

// File: tb/tb_ul_lite_uart.sv
module tb_ul_lite_uart;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [31:0] wdata = '0, rdata, v;
  logic        rxd = 1'b1, txd, irq;

  int n_chk = 0, n_err = 0, irq_cnt = 0, irq0;
  bit done = 0, ie_m = 0, ie_prev = 0;
  logic [6:0] tx_seen[$];

  always #5 clk = ~clk;

  ul_lite_uart #(.TICK_DIV(2), .DATA_BITS(7), .PARITY_EN(1), .PARITY_ODD(1), .FIFO_DEPTH(16)) dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .re_i(re),
    .wdata_i(wdata), .rdata_o(rdata), .rxd_i(rxd), .txd_o(txd), .irq_o(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
    if (a == 4'hC) ie_m = d[4];
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; re = 1'b1; #1 d = rdata;
    @(negedge clk); re = 1'b0;
  endtask

  // 32 clocks per bit (TICK_DIV 2 x 16)
  task automatic send(input logic [6:0] ch, input bit bad_par, input bit bad_stop);
    logic [9:0] f;
    f = {~bad_stop, (~^ch) ^ bad_par, ch, 1'b0};
    for (int i = 0; i < 10; i++) begin
      rxd = f[i];
      repeat (32) @(negedge clk);
    end
    rxd = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic wait_seen(input int n);
    for (int i = 0; i < 12000 && tx_seen.size() < n; i++) @(negedge clk);
  endtask

  // serial decoder for txd
  initial begin
    logic [8:0] b;
    forever begin
      @(negedge txd);
      repeat (16) @(negedge clk);
      for (int i = 0; i < 9; i++) begin
        repeat (32) @(negedge clk);
        b[i] = txd;
      end
      chk("R4 parity", {31'd0, ^b[7:0]}, 32'd1);
      chk("R4 stop", {31'd0, b[8]}, 32'd1);
      tx_seen.push_back(b[6:0]);
    end
  end

  always @(posedge irq) irq_cnt++;

  // per-clock: no interrupt while disabled (R10)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (!ie_prev) chk("R10 irq while disabled", {31'd0, irq}, 32'd0);
      ie_prev <= ie_m;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 txd", {31'd0, txd}, 32'd1);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    rd(4'h8, v); chk("R1 status", v, 32'h04);
    rd(4'h0, v); chk("R1 rx read", v, 32'h0);

    // R9
    wr(4'hC, 32'h10);
    rd(4'h8, v); chk("R9 ie set", v, 32'h14);

    // R2 / R10 receive
    irq0 = irq_cnt;
    send(7'h2A, 0, 0);
    rd(4'h8, v); chk("R2 valid", v, 32'h15);
    chk("R10 rx irq", irq_cnt, irq0 + 1);
    rd(4'h0, v); chk("R2 data", v, 32'h2A);
    rd(4'h0, v); chk("R3 empty read", v, 32'h0);
    rd(4'h8, v); chk("R3 no pop", v, 32'h14);
    send(7'h7F, 0, 0);
    rd(4'h0, v); chk("R2 zero extend", v, 32'h7F);

    // R7 parity and framing, sticky until status read
    send(7'h11, 1, 0);
    rd(4'h8, v); chk("R7 parity set", v, 32'h95);
    rd(4'h8, v); chk("R7 parity clear", v, 32'h15);
    rd(4'h0, v); chk("R7 data", v, 32'h11);
    send(7'h05, 0, 1);
    rd(4'h8, v); chk("R7 frame set", v, 32'h55);
    rd(4'h8, v); chk("R7 frame clear", v, 32'h15);
    rd(4'h0, v); chk("R7 data", v, 32'h05);

    // R6 overrun
    for (int i = 0; i < 17; i++) send(7'(8'h30 + i), 0, 0);
    rd(4'h8, v); chk("R6 full+overrun", v, 32'h37);
    for (int i = 0; i < 16; i++) begin
      rd(4'h0, v); chk("R6 order", v, 32'h30 + i);
    end
    rd(4'h8, v); chk("R6 drained", v, 32'h14);
    rd(4'h0, v); chk("R6 17th dropped", v, 32'h0);

    // R8 rx flush
    send(7'h01, 0, 0);
    send(7'h02, 0, 0);
    wr(4'hC, 32'h12);
    rd(4'h8, v); chk("R8 rx flush", v, 32'h14);

    // R9 / R10 disabled
    wr(4'hC, 32'h00);
    rd(4'h8, v); chk("R9 ie clear", v, 32'h04);
    irq0 = irq_cnt;
    send(7'h33, 0, 0);
    rd(4'h8, v); chk("R9 status", v, 32'h05);
    chk("R10 no irq", irq_cnt, irq0);
    rd(4'h0, v); chk("R2 data", v, 32'h33);

    // R4 transmit + R10 tx empty irq
    wr(4'hC, 32'h10);
    irq0 = irq_cnt;
    tx_seen.delete();
    wr(4'h4, 32'h41); wr(4'h4, 32'h5A); wr(4'h4, 32'h03);
    wait_seen(3);
    chk("R4 count", tx_seen.size(), 3);
    if (tx_seen.size() == 3) begin
      chk("R4 char0", {25'd0, tx_seen[0]}, 32'h41);
      chk("R4 char1", {25'd0, tx_seen[1]}, 32'h5A);
      chk("R4 char2", {25'd0, tx_seen[2]}, 32'h03);
    end
    chk("R10 tx irq", irq_cnt, irq0 + 2);
    rd(4'h8, v); chk("R4 idle status", v, 32'h14);

    // R5 full transmit FIFO
    wr(4'hC, 32'h00);
    tx_seen.delete();
    for (int i = 0; i < 18; i++) wr(4'h4, 32'h40 + i);
    rd(4'h8, v); chk("R5 full", v, 32'h08);
    wait_seen(17);
    repeat (400) @(negedge clk);
    chk("R5 count", tx_seen.size(), 17);
    for (int i = 0; i < 17 && i < tx_seen.size(); i++)
      chk("R5 order", {25'd0, tx_seen[i]}, 32'h40 + i);

    // R8 tx flush
    tx_seen.delete();
    for (int i = 0; i < 5; i++) wr(4'h4, 32'h20 + i);
    wr(4'hC, 32'h01);
    rd(4'h8, v); chk("R8 tx flush", v, 32'h04);
    repeat (800) @(negedge clk);
    chk("R8 only in-flight sent", tx_seen.size(), 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule